// File: doc/BRIEF.md
# Interrupt Priority Resolver with Level Rounding

This block picks one winner among the interrupt requests that reach an interrupt controller. Sixteen on-chip sources each carry a 5-bit programmable priority held in an internal register file. A non-maskable request and one external request with its own 4-bit level also take part. The on-chip sources are compared at the full 5-bit precision. The winning value is then shown to the processor at 4 bits by dropping its least significant bit. The external request is compared against that rounded level, so a coarse external level can displace a finer on-chip winner.

The resolution is combinational from the stored priorities and the live request inputs. The block drives an interrupt request toward the processor together with the winner's 4-bit level. On a single-cycle acknowledge pulse it captures the winner's unique event code and level into output registers. These hold their values until the next acknowledge, so software can use the event code as a branch offset.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset every on-chip priority is 0, `evt_code` and `evt_level` are 0, and on-chip requests alone raise no interrupt.
- R2: An on-chip source whose priority field is 0 or 1 is masked. It never wins, and with no other request pending `win_level` stays 0 and `irq_req` stays low.
- R3: The 4-bit level of an on-chip winner is its 5-bit priority shifted right by one. For example, priority 2 gives level 1 and priority 31 gives level 15.
- R4: Among pending on-chip sources, the higher 5-bit priority wins even when both round to the same 4-bit level (27 beats 26).
- R5: Pending on-chip sources with equal 5-bit priority are resolved in favour of the lower source index.
- R6: A pending `nmi_req` always wins, with level 15 and code 0x1C0. It raises `irq_req` regardless of `cpu_mask` and `irq_block`.
- R7: A pending external request with a nonzero `ext_level` wins when that level is equal to or greater than the rounded on-chip level, and it carries code 0x200. An external level of 0 takes no part.
- R8: Apart from NMI, `irq_req` is high only when `win_level` is strictly greater than `cpu_mask` and `irq_block` is low.
- R9: On-chip source i carries event code 0x400 + 0x20*i. When there is no winner, the code is 0.
- R10: The rising edge on which `ack` is high loads `evt_code` and `evt_level` with the current winner. Without `ack` they hold their values.
- R11: A write with `cfg_we` high sets the priority of source `cfg_addr` to `cfg_wdata`, and the new value takes effect at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Priority register write enable |
| cfg_addr | input | 4 | Source index to write |
| cfg_wdata | input | 5 | Priority value to write |
| src_req | input | 16 | Level-sensitive on-chip requests |
| nmi_req | input | 1 | Non-maskable request |
| ext_req | input | 1 | External request |
| ext_level | input | 4 | External request level |
| cpu_mask | input | 4 | Processor mask level |
| irq_block | input | 1 | Suppresses all non-NMI requests |
| ack | input | 1 | One-cycle acknowledge pulse |
| irq_req | output | 1 | Interrupt request to the processor |
| win_level | output | 4 | Current winner's rounded level |
| evt_code | output | 12 | Event code latched on acknowledge |
| evt_level | output | 4 | Level latched on acknowledge |

## Verification
The bench sets two sources at priorities 26 and 27, which round to the same level. A design that arbitrated on the rounded value would then report the wrong event code. Priority 1 is checked to stay silent, so a design that treated 1 as a valid level would raise a spurious request. The external request is tried at exactly the rounded level and one below it: getting the comparison wrong flips the winner at that boundary. A level equal to `cpu_mask` must stay unrequested, and an unacknowledged change of inputs must leave the latched code alone.

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int N_SRC       = 16,
  parameter int PW          = 5,
  parameter int CW          = 12,
  parameter int ONCHIP_BASE = 'h400,
  parameter int CODE_STEP   = 'h20,
  parameter int EXT_CODE    = 'h200,
  parameter int NMI_CODE    = 'h1C0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(N_SRC)-1:0]  cfg_addr,
  input  logic [PW-1:0]             cfg_wdata,
  input  logic [N_SRC-1:0]          src_req,
  input  logic                      nmi_req,
  input  logic                      ext_req,
  input  logic [PW-2:0]             ext_level,
  input  logic [PW-2:0]             cpu_mask,
  input  logic                      irq_block,
  input  logic                      ack,
  output logic                      irq_req,
  output logic [PW-2:0]             win_level,
  output logic [CW-1:0]             evt_code,
  output logic [PW-2:0]             evt_level
);
  localparam int LW = PW - 1;
  localparam int IW = $clog2(N_SRC);
  localparam logic [LW-1:0] TOP_LVL = '1;

  logic [PW-1:0] pri_q [N_SRC];
  logic [PW-1:0] on_lvl5;
  logic [IW-1:0] on_idx;
  logic          on_valid, ext_valid, ext_wins;
  logic [LW-1:0] on_lvl4;
  logic [CW-1:0] win_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SRC; i++) pri_q[i] <= '0;
    end else if (cfg_we) begin
      pri_q[cfg_addr] <= cfg_wdata;
    end
  end

  always_comb begin
    on_lvl5 = '0;
    on_idx  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (src_req[i] && pri_q[i] >= PW'(2) && pri_q[i] >= on_lvl5) begin
        on_lvl5 = pri_q[i];
        on_idx  = IW'(i);
      end
    end
  end

  assign on_valid  = on_lvl5 != '0;
  assign on_lvl4   = on_lvl5[PW-1:1];
  assign ext_valid = ext_req && ext_level != '0;
  assign ext_wins  = ext_valid && (!on_valid || ext_level >= on_lvl4);

  assign win_level = nmi_req  ? TOP_LVL :
                     ext_wins ? ext_level :
                     on_valid ? on_lvl4 : '0;

  assign win_code  = nmi_req  ? CW'(NMI_CODE) :
                     ext_wins ? CW'(EXT_CODE) :
                     on_valid ? CW'(ONCHIP_BASE) + CW'(CODE_STEP) * CW'(on_idx) : '0;

  assign irq_req = nmi_req || (!irq_block && win_level > cpu_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_code  <= '0;
      evt_level <= '0;
    end else if (ack) begin
      evt_code  <= win_code;
      evt_level <= win_level;
    end
  end

  AST_MASKED_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    on_valid |-> on_lvl5 >= PW'(2)); // R2
  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> irq_req && win_level == TOP_LVL && win_code == CW'(NMI_CODE)); // R6
  AST_EXT_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_req && ext_req && ext_level != '0 && ext_level >= on_lvl4) |-> win_code == CW'(EXT_CODE)); // R7
  AST_NO_IRQ_BELOW_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_req && (irq_block || win_level <= cpu_mask)) |-> !irq_req); // R8
  AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> evt_code == $past(win_code) && evt_level == $past(win_level)); // R10
  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(evt_code) && $stable(evt_level)); // R10
endmodule

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [3:0] cfg_addr = 0; logic [4:0] cfg_wdata = 0;
  logic [15:0] src_req = 0;
  logic nmi_req = 0, ext_req = 0, irq_block = 0, ack = 0;
  logic [3:0] ext_level = 0, cpu_mask = 0;
  logic irq_req; logic [3:0] win_level, evt_level; logic [11:0] evt_code;
  int nvec = 0, nbad = 0;

  always #2.5 clk = ~clk;

  irq_prio_resolver dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .src_req(src_req), .nmi_req(nmi_req), .ext_req(ext_req),
    .ext_level(ext_level), .cpu_mask(cpu_mask), .irq_block(irq_block), .ack(ack),
    .irq_req(irq_req), .win_level(win_level), .evt_code(evt_code), .evt_level(evt_level));

  typedef struct packed {
    logic [7:0]  tag;
    logic [15:0] src;
    logic        nmi, ext;
    logic [3:0]  elvl, mask;
    logic        blk, e_irq;
    logic [3:0]  e_lvl;
    logic [11:0] e_code;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{8'd3,  16'h0001, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0, 1'b1, 4'd13, 12'h400}, // R3 src0 pri 26
    '{8'd4,  16'h0003, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0, 1'b1, 4'd13, 12'h420}, // R4 27 beats 26
    '{8'd5,  16'h0006, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0, 1'b1, 4'd13, 12'h420}, // R5 tie, lower index
    '{8'd2,  16'h0008, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0, 1'b0, 4'd0,  12'h000}, // R2 pri 1 masked
    '{8'd3,  16'h0010, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0, 1'b1, 4'd1,  12'h480}, // R3 pri 2 -> 1
    '{8'd8,  16'h0010, 1'b0, 1'b0, 4'd0,  4'd1,  1'b0, 1'b0, 4'd1,  12'h480}, // R8 equal to mask
    '{8'd2,  16'h0020, 1'b0, 1'b0, 4'd0,  4'd0,  1'b0, 1'b0, 4'd0,  12'h000}, // R2 pri 0 masked
    '{8'd7,  16'h0001, 1'b0, 1'b1, 4'd13, 4'd0,  1'b0, 1'b1, 4'd13, 12'h200}, // R7 ext equal wins
    '{8'd7,  16'h0001, 1'b0, 1'b1, 4'd12, 4'd0,  1'b0, 1'b1, 4'd13, 12'h400}, // R7 ext below loses
    '{8'd7,  16'h8000, 1'b0, 1'b1, 4'd15, 4'd0,  1'b0, 1'b1, 4'd15, 12'h200}, // R7 ext vs pri 31
    '{8'd6,  16'h0080, 1'b1, 1'b1, 4'd15, 4'd15, 1'b1, 1'b1, 4'd15, 12'h1C0}, // R6 NMI over all
    '{8'd8,  16'h0001, 1'b0, 1'b0, 4'd0,  4'd0,  1'b1, 1'b0, 4'd13, 12'h400}, // R8 blocked
    '{8'd7,  16'h0080, 1'b0, 1'b1, 4'd0,  4'd0,  1'b0, 1'b1, 4'd5,  12'h4E0}, // R7 ext level 0 ignored
    '{8'd9,  16'h0000, 1'b0, 1'b1, 4'd3,  4'd2,  1'b0, 1'b1, 4'd3,  12'h200}, // R9 ext alone
    '{8'd9,  16'h8000, 1'b0, 1'b0, 4'd0,  4'd14, 1'b0, 1'b1, 4'd15, 12'h5E0}  // R9 source 15 code
  };

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 5'(d);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; @(negedge clk); ack = 0;
  endtask

  initial begin
    #200000;
    nbad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    src_req = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", irq_req, 0);
    chk("R1 level after reset", win_level, 0);
    chk("R1 evt_code after reset", evt_code, 0);
    chk("R1 evt_level after reset", evt_level, 0);
    src_req = 0;

    // R11: the write lands on the edge
    src_req = 16'h0400;
    @(negedge clk); cfg_we = 1; cfg_addr = 4'd10; cfg_wdata = 5'd9;
    #1 chk("R11 before write edge", win_level, 0);
    @(negedge clk); cfg_we = 0;
    chk("R11 after write edge", win_level, 4);
    wr(10, 0);
    chk("R11 cleared back", win_level, 0);
    src_req = 0;

    wr(0, 26); wr(1, 27); wr(2, 27); wr(3, 1); wr(4, 2); wr(5, 0); wr(7, 10); wr(15, 31);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d vec%0d", VT[i].tag, i);
      @(negedge clk);
      src_req = VT[i].src; nmi_req = VT[i].nmi; ext_req = VT[i].ext;
      ext_level = VT[i].elvl; cpu_mask = VT[i].mask; irq_block = VT[i].blk;
      #1;
      chk({t, " irq"}, irq_req, VT[i].e_irq);
      chk({t, " level"}, win_level, VT[i].e_lvl);
      pulse_ack();
      chk({t, " code"}, evt_code, VT[i].e_code);
      chk({t, " latched level"}, evt_level, VT[i].e_lvl);
    end

    // R10: no ack, inputs change, latch holds
    src_req = 16'h0001; nmi_req = 0; ext_req = 0; irq_block = 0; cpu_mask = 0;
    pulse_ack();
    chk("R10 captured", evt_code, 12'h400);
    src_req = 16'h0002;
    repeat (3) @(negedge clk);
    chk("R10 hold code", evt_code, 12'h400);
    chk("R10 live winner moved", win_level, 13);
    pulse_ack();
    chk("R10 recapture", evt_code, 12'h420);

    // R8: strict comparison at the top and just below
    src_req = 16'h8000; cpu_mask = 4'd15;
    #1 chk("R8 level 15 vs mask 15", irq_req, 0);
    cpu_mask = 4'd14;
    #1 chk("R8 level 15 vs mask 14", irq_req, 1);
    src_req = 0;

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule